// File: doc/BRIEF.md
# Start/Stop Character Receiver with Word Queue

This block turns a start/stop framed serial line into parallel words. The line is examined only on cycles where a sixteen-times-bit-rate enable is high. A falling level opens a character; it is confirmed at the middle of the start bit, and then each data bit is taken at its own centre. The start and stop bits are removed, and the data word goes into a small queue that a downstream synchronous transmitter reads with a pop strobe.

Characters carry eight or nine data bits, chosen by a mode input. A low level that lasts much longer than any legal character is reported as a line break through its own flag. The block does not queue a word for a break. A status output behaves like a clear-to-send line: it drops as soon as the queue starts to back up, well before the queue is full. This leaves the sender time to pause.

Top module: `async_word_stripper`

## Requirements
- R1: A character is one low start bit, then the data bits least significant bit first, then a high stop bit. With `wide_word` high there are 9 data bits; with it low there are 8 data bits and `rd_data[8]` reads 0. The word appears right-aligned in `rd_data`.
- R2: The line is examined only on cycles where `tick_16x` is high. The start bit is confirmed on the 8th tick after the tick that first saw the line low. Each later bit, including the stop bit, is sampled 16 ticks after the previous sample.
- R3: If the line is high again at the start-bit confirmation tick, the character is dropped as a false start. No word is queued, and the next falling level is accepted as a new start.
- R4: A character whose stop-bit sample is low is discarded. The receiver then waits for the line to return high before it looks for a new start.
- R5: `line_break` rises once the line has been low for 176 consecutive ticks (11 bit times). It stays low while the line has been low for fewer ticks. It clears once the line is seen high again.
- R6: Received words leave the queue in arrival order. The queue holds up to 4 words. `rd_valid` is high while the queue is not empty, and a cycle with `rd_pop` high and `rd_valid` high removes the head word.
- R7: A word that arrives while 4 words are already queued is lost. The 4 queued words are kept unchanged.
- R8: `tx_ready` is low while 2 or more words are queued and high while 0 or 1 words are queued.
- R9: While `rst_n` is low, the queue is emptied, the line is treated as high (so no break can be flagged), and `tx_ready` is low. `tx_ready` is high in the first cycle after `rst_n` returns high.
- R10: While `rd_valid` is high and no pop occurs, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_16x | input | 1 | Enable at sixteen times the bit rate |
| rx_line | input | 1 | Serial line, idle high |
| wide_word | input | 1 | High selects 9 data bits, low selects 8 |
| rd_data | output | 9 | Word at the head of the queue |
| rd_valid | output | 1 | Queue holds at least one word |
| rd_pop | input | 1 | Remove the head word |
| line_break | output | 1 | Long low level detected |
| tx_ready | output | 1 | High while fewer than 2 words are queued |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, a 4-deep queue, a 9-bit maximum word, a status threshold of 2 and an 11-bit break. With these values every 8-bit code can be swept, along with a third of the 9-bit codes, all within the run time. Most of the run holds the tick enable high on every cycle, so each character costs only about 200 cycles. A later phase spaces the ticks three cycles apart to show that only enabled cycles advance the receiver. The small queue depth lets the bench fill the queue, overflow it, and watch the status threshold in a handful of characters.

// File: rtl/aws_pkg.sv
package aws_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP,
        FR_WAIT
    } frame_state_e;

endpackage

// File: rtl/aws_framer.sv
module aws_framer #(
    parameter int OSR  = 16,
    parameter int WMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            line,
    input  logic            wide,
    output logic            push,
    output logic [WMAX-1:0] push_word
);
    import aws_pkg::*;

    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(WMAX + 1);
    localparam int MID = OSR / 2 - 1;

    typedef struct packed {
        frame_state_e    state;
        logic [CW-1:0]   cnt;
        logic [BW-1:0]   nbit;
        logic [WMAX-1:0] shreg;
        logic            push;
        logic [WMAX-1:0] word;
    } framer_t;

    framer_t st_d, st_q;
    logic [BW-1:0] last_idx;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        last_idx  = wide ? BW'(WMAX - 1) : BW'(WMAX - 2);
        if (tick) begin
            case (st_q.state)
                FR_IDLE: begin
                    if (!line) begin
                        st_d.state = FR_START;
                        st_d.cnt   = '0;
                    end
                end
                FR_START: begin
                    if (st_q.cnt == CW'(MID)) begin
                        st_d.cnt = '0;
                        if (!line) begin
                            st_d.state = FR_DATA;
                            st_d.nbit  = '0;
                            st_d.shreg = '0;
                        end else begin
                            st_d.state = FR_IDLE;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                FR_DATA: begin
                    if (st_q.cnt == CW'(OSR - 1)) begin
                        st_d.cnt   = '0;
                        st_d.shreg = {line, st_q.shreg[WMAX-1:1]};
                        st_d.nbit  = st_q.nbit + 1'b1;
                        if (st_q.nbit == last_idx) begin
                            st_d.state = FR_STOP;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                FR_STOP: begin
                    if (st_q.cnt == CW'(OSR - 1)) begin
                        st_d.cnt = '0;
                        if (line) begin
                            st_d.push  = 1'b1;
                            st_d.word  = wide ? st_q.shreg : (st_q.shreg >> 1);
                            st_d.state = FR_IDLE;
                        end else begin
                            st_d.state = FR_WAIT;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                FR_WAIT: begin
                    if (line) begin
                        st_d.state = FR_IDLE;
                    end
                end
                default: st_d.state = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: FR_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign push      = st_q.push;
    assign push_word = st_q.word;

endmodule

// File: rtl/aws_break.sv
module aws_break #(
    parameter int OSR        = 16,
    parameter int BREAK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic brk
);
    localparam int LIMIT = OSR * BREAK_BITS;
    localparam int KW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [KW-1:0] cnt;
        logic          flag;
    } brk_t;

    brk_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (line) begin
            b_d.cnt = '0;
        end else if (tick && (b_q.cnt != KW'(LIMIT))) begin
            b_d.cnt = b_q.cnt + 1'b1;
        end
        b_d.flag = (b_d.cnt == KW'(LIMIT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign brk = b_q.flag;

endmodule

// File: rtl/aws_fifo.sv
module aws_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_word,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       valid,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd_ptr;
        logic [PW-1:0]           wr_ptr;
        logic [FW-1:0]           count;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d     = f_q;
        do_push = push && (f_q.count != FW'(DEPTH));
        do_pop  = pop && (f_q.count != '0);
        if (do_push) begin
            f_d.mem[f_q.wr_ptr] = push_word;
            f_d.wr_ptr          = wrap_inc(f_q.wr_ptr);
        end
        if (do_pop) begin
            f_d.rd_ptr = wrap_inc(f_q.rd_ptr);
        end
        case ({do_push, do_pop})
            2'b10:   f_d.count = f_q.count + 1'b1;
            2'b01:   f_d.count = f_q.count - 1'b1;
            default: f_d.count = f_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign head  = f_q.mem[f_q.rd_ptr];
    assign valid = (f_q.count != '0);
    assign fill  = f_q.count;

endmodule

// File: rtl/async_word_stripper.sv
module async_word_stripper #(
    parameter int OSR          = 16,
    parameter int WMAX         = 9,
    parameter int DEPTH        = 4,
    parameter int STATUS_LEVEL = 2,
    parameter int BREAK_BITS   = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_16x,
    input  logic            rx_line,
    input  logic            wide_word,
    output logic [WMAX-1:0] rd_data,
    output logic            rd_valid,
    input  logic            rd_pop,
    output logic            line_break,
    output logic            tx_ready
);
    localparam int FW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sy_d, sy_q;
    logic            line_s;
    logic            push;
    logic [WMAX-1:0] push_word;
    logic [FW-1:0]   fill;

    always_comb begin
        sy_d.s1 = rx_line;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy_q <= '{s1: 1'b1, s2: 1'b1};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign line_s = sy_q.s2;

    aws_framer #(.OSR(OSR), .WMAX(WMAX)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_16x),
        .line      (line_s),
        .wide      (wide_word),
        .push      (push),
        .push_word (push_word)
    );

    aws_break #(.OSR(OSR), .BREAK_BITS(BREAK_BITS)) u_break (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_16x),
        .line  (line_s),
        .brk   (line_break)
    );

    aws_fifo #(.W(WMAX), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (rd_pop),
        .head      (rd_data),
        .valid     (rd_valid),
        .fill      (fill)
    );

    assign tx_ready = rst_n && (fill < FW'(STATUS_LEVEL));

endmodule

// File: rtl/aws_checker.sv
module aws_checker #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tx_ready,
    input logic                       rd_valid,
    input logic                       rd_pop,
    input logic [W-1:0]               rd_data,
    input logic                       line_break,
    input logic                       line_s,
    input logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int FW = $clog2(DEPTH + 1);

    // R8: status low means words are waiting
    p_status_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |-> rd_valid);

    // R7: occupancy never exceeds the depth
    p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));

    // R7: a full queue without a pop stays full
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FW'(DEPTH)) && !rd_pop |=> (fill == FW'(DEPTH)));

    // R10: head word held while not popped
    p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_pop |=> rd_valid && $stable(rd_data));

    // R5: break flag drops after the line is seen high
    p_break_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_break && line_s |=> !line_break);

    // R9: status low throughout reset
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            p_reset_status_r9: assert (tx_ready === 1'b0);
        end
    end

endmodule

bind async_word_stripper aws_checker #(.W(WMAX), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_ready   (tx_ready),
    .rd_valid   (rd_valid),
    .rd_pop     (rd_pop),
    .rd_data    (rd_data),
    .line_break (line_break),
    .line_s     (line_s),
    .fill       (fill)
);

// File: tb/test_async_word_stripper.sv
module test_async_word_stripper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b0;
    logic       rx_line = 1'b1;
    logic       wide_word = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid;
    logic       rd_pop = 1'b0;
    logic       line_break;
    logic       tx_ready;

    int  n_checks = 0;
    int  n_fails = 0;
    int  tick_period = 1;
    int  tcnt = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    async_word_stripper i_async_word_stripper (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_16x   (tick_16x),
        .rx_line    (rx_line),
        .wide_word  (wide_word),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_pop     (rd_pop),
        .line_break (line_break),
        .tx_ready   (tx_ready)
    );

    always @(negedge clk) begin
        if (tcnt >= tick_period - 1) tcnt = 0;
        else tcnt = tcnt + 1;
        tick_16x = (tcnt == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold_ticks(input int n);
        repeat (n * tick_period) @(negedge clk);
    endtask

    task automatic send_char(input int val, input int nbits, input bit stop_ok);
        rx_line = 1'b0;
        hold_ticks(16);
        for (int i = 0; i < nbits; i++) begin
            rx_line = val[i];
            hold_ticks(16);
        end
        rx_line = stop_ok;
        hold_ticks(16);
        rx_line = 1'b1;
        hold_ticks(16);
    endtask

    task automatic pop_expect(input int exp, input string req);
        #1;
        check(rd_valid === 1'b1, req, int'(rd_valid), 1);
        check(int'(rd_data) == exp, req, int'(rd_data), exp);
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (5) @(negedge clk);
        #1;
        check(tx_ready === 1'b0, "R9", int'(tx_ready), 0);
        check(rd_valid === 1'b0, "R9", int'(rd_valid), 0);
        check(line_break === 1'b0, "R9", int'(line_break), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(tx_ready === 1'b1, "R9", int'(tx_ready), 1);
        hold_ticks(20);

        // R1, R2: full 8-bit sweep
        wide_word = 1'b0;
        for (int v = 0; v < 256; v++) begin
            send_char(v, 8, 1'b1);
            if (v == 0) begin
                #1;
                check(tx_ready === 1'b1, "R8", int'(tx_ready), 1);
            end
            pop_expect(v, "R1");
        end

        // R1: 9-bit mode sweep
        wide_word = 1'b1;
        for (int i = 0; i < 171; i++) begin
            send_char(i * 3, 9, 1'b1);
            pop_expect(i * 3, "R1");
        end
        wide_word = 1'b0;

        // R3: false start rejected, receiver recovers
        rx_line = 1'b0;
        hold_ticks(4);
        rx_line = 1'b1;
        hold_ticks(40);
        #1;
        check(rd_valid === 1'b0, "R3", int'(rd_valid), 0);
        send_char(8'hA5, 8, 1'b1);
        pop_expect(8'hA5, "R3");

        // R4: low stop bit discards the word
        send_char(8'h3C, 8, 1'b0);
        #1;
        check(rd_valid === 1'b0, "R4", int'(rd_valid), 0);
        send_char(8'h5A, 8, 1'b1);
        pop_expect(8'h5A, "R4");

        // R5: break detection threshold and clearing
        rx_line = 1'b0;
        hold_ticks(160);
        #1;
        check(line_break === 1'b0, "R5", int'(line_break), 0);
        hold_ticks(32);
        #1;
        check(line_break === 1'b1, "R5", int'(line_break), 1);
        rx_line = 1'b1;
        hold_ticks(8);
        #1;
        check(line_break === 1'b0, "R5", int'(line_break), 0);
        check(rd_valid === 1'b0, "R4", int'(rd_valid), 0);
        hold_ticks(16);

        // R6, R7, R8, R10: fill past capacity
        for (int k = 0; k < 5; k++) begin
            send_char(8'h11 * (k + 1), 8, 1'b1);
            #1;
            if (k == 0) check(tx_ready === 1'b1, "R8", int'(tx_ready), 1);
            if (k == 1) check(tx_ready === 1'b0, "R8", int'(tx_ready), 0);
        end
        begin
            logic [8:0] snap;
            #1;
            snap = rd_data;
            repeat (20) @(negedge clk);
            #1;
            check(rd_data === snap, "R10", int'(rd_data), int'(snap));
        end
        for (int k = 0; k < 4; k++) begin
            pop_expect(8'h11 * (k + 1), "R6");
        end
        #1;
        check(rd_valid === 1'b0, "R7", int'(rd_valid), 0);
        check(tx_ready === 1'b1, "R8", int'(tx_ready), 1);

        // R2: sparse tick enable
        tick_period = 3;
        for (int k = 0; k < 3; k++) begin
            send_char(8'h96 ^ k, 8, 1'b1);
            pop_expect(8'h96 ^ k, "R2");
        end
        tick_period = 1;

        // R9: reset clears queue and masks the line
        send_char(8'h42, 8, 1'b1);
        send_char(8'h24, 8, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        rx_line = 1'b0;
        hold_ticks(200);
        #1;
        check(rd_valid === 1'b0, "R9", int'(rd_valid), 0);
        check(tx_ready === 1'b0, "R9", int'(tx_ready), 0);
        check(line_break === 1'b0, "R9", int'(line_break), 0);
        rx_line = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(tx_ready === 1'b1, "R9", int'(tx_ready), 1);
        hold_ticks(20);
        check(rd_valid === 1'b0, "R9", int'(rd_valid), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule